// File: doc/BRIEF.md
# Weighted Multi-Path Packet Injector

This block sits at the sending side of a network interface that can reach a destination over several disjoint routes. For every packet handed to it, the injector stamps a per-flow sequence number and picks one route for it at random, with each route's share of the traffic set by programmable weights. A receiver that expects sequence numbers in strict order can then restore packet order where the routes meet again, without dropping anything.

Traffic marked critical is sent more than once, with the number of copies configured per flow, so that one corrupted copy or one broken route does not lose the packet. Every copy draws its own route. While copies are still going out, the injector holds off new requests. Weights and copy counts are written through a simple configuration port, and the weights themselves are computed offline.

Top module: `mpinj_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `outValid` is 0 and `reqReady` is 1. Reset returns every flow's next sequence number to 1, every flow's copy count to 1, and every flow's thresholds for routes 0..3 to 64, 128, 192, 255.
- R2: A request is taken at a rising edge where `reqValid` and `reqReady` are both 1. Its first emission appears on the outputs after that same edge, with `outFlow` and `outHandle` equal to the request's flow and handle and `outCopy` equal to 0.
- R3: Each flow keeps its own 8-bit sequence counter. The first packet taken for a flow after reset carries 1, and each later packet taken for that flow carries the previous value plus one, wrapping from 255 to 0. Traffic on one flow never changes another flow's counter.
- R4: The random source is a 16-bit shift register seeded with 0xACE1 at reset. Each cycle it shifts left by one, and its new bit 0 is the XOR of bits 15, 13, 12 and 10. For an emission produced at an edge, the random byte is bits 7:0 of the register value held just before that edge. The route `outPath` is the lowest index p in 0..3 whose threshold for the emission's flow is greater than the random byte. If no threshold is greater, the route is 3.
- R5: A critical request whose flow copy count N is at least 2 gives N emissions on N consecutive cycles. These carry `outCopy` 0 to N-1, the same sequence number, flow and handle, and each its own route draw under R4. A copy count of 0 or 1, or a request that is not critical, gives exactly one emission. After the last emission, `outValid` is 0 unless a new request was taken.
- R6: `reqReady` is 0 from the cycle after a multi-copy request is taken until the cycle whose outputs show its last copy, when it is 1 again. A request presented while `reqReady` is 0 is ignored. It produces no emission and advances no counter.
- R7: A configuration write (`cfgWrite` high at an edge) to flow `cfgFlow` sets the threshold of route `cfgAddr` when `cfgAddr` is 0..3, and sets the copy count from `cfgData[2:0]` when `cfgAddr` is 4. Addresses 5..7 change nothing. A write applies to every route draw made at later edges.
- R8: The random register advances on every clock edge after reset, whether or not packets are flowing, so an idle gap changes the routes that later packets draw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A packet request is presented |
| reqFlow | input | 2 | Flow index of the request |
| reqCritical | input | 1 | Request is to be replicated per its flow's copy count |
| reqHandle | input | 16 | Opaque payload handle carried to the output |
| reqReady | output | 1 | Injector can take a request this cycle |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgFlow | input | 2 | Flow whose configuration is written |
| cfgAddr | input | 3 | 0..3 route threshold, 4 copy count, 5..7 unused |
| cfgData | input | 8 | Threshold value or copy count in bits 2:0 |
| outValid | output | 1 | An emission is on the outputs |
| outFlow | output | 2 | Flow of the emission |
| outHandle | output | 16 | Payload handle of the emission |
| outPath | output | 2 | Chosen route index |
| outSeqId | output | 8 | Sequence number of the emission |
| outCopy | output | 3 | Copy index within a replicated packet |

## Verification
A corrupted per-flow counter shows up on the very next emission of that flow, as a sequence number that does not match one plus the last one taken. A replication counter that is off by one shows within the few cycles of a critical packet, either as a missing or extra copy or as `reqReady` rising a cycle early or late. A random register out of step with its defined sequence shows as a wrong `outPath` on the first packet whose flow has thresholds that split the byte range, so the bench keeps such flows busy across idle gaps and threshold rewrites.

// File: rtl/mpinj_pkg.sv
`timescale 1ns/1ps
package mpinj_pkg;
  localparam int COPY_W = 3;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef struct packed {
    logic              capture;
    logic              emit;
    logic [COPY_W-1:0] copyNum;
  } ctrl_strobe_t;
endpackage

// File: rtl/mpinj_lfsr.sv
`timescale 1ns/1ps
module mpinj_lfsr
  import mpinj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);
  logic feedback;
  assign feedback = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LFSR_SEED;
    else        state <= {state[LFSR_W-2:0], feedback};
  end

  // R8: the register never locks up at zero
  assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R8: it moves on every edge
  assert_lfsr_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> state != $past(state));
endmodule

// File: rtl/mpinj_path_pick.sv
`timescale 1ns/1ps
module mpinj_path_pick #(
  parameter int NUM_PATHS = 4,
  parameter int WEIGHT_W  = 8,
  localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
  input  logic [WEIGHT_W-1:0]           randVal,
  input  logic [NUM_PATHS*WEIGHT_W-1:0] thrRow,
  output logic [PATH_W-1:0]             path
);
  always_comb begin
    path = PATH_W'(NUM_PATHS - 1);
    for (int p = NUM_PATHS - 1; p >= 0; p--) begin
      if (randVal < thrRow[p*WEIGHT_W +: WEIGHT_W]) path = PATH_W'(p);
    end
  end
endmodule

// File: rtl/mpinj_ctrl.sv
`timescale 1ns/1ps
module mpinj_ctrl
  import mpinj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqCritical,
  input  logic [COPY_W-1:0] reqCopies,
  output logic              reqReady,
  output ctrl_strobe_t      strobe
);
  logic              busy;
  logic [COPY_W-1:0] left;
  logic [COPY_W-1:0] copyIdx;
  logic              accept;

  assign accept   = reqValid && !busy;
  assign reqReady = !busy;

  always_comb begin
    strobe.capture = accept;
    strobe.emit    = accept || busy;
    strobe.copyNum = busy ? copyIdx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      left    <= '0;
      copyIdx <= '0;
    end else if (accept) begin
      if (reqCritical && reqCopies > COPY_W'(1)) begin
        busy    <= 1'b1;
        left    <= reqCopies - COPY_W'(1);
        copyIdx <= COPY_W'(1);
      end
    end else if (busy) begin
      if (left == COPY_W'(1)) busy <= 1'b0;
      left    <= left - COPY_W'(1);
      copyIdx <= copyIdx + COPY_W'(1);
    end
  end

  // R5: copies step by one while more remain
  assert_copy_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left != COPY_W'(1)) |=> (busy && copyIdx == $past(copyIdx) + COPY_W'(1)));
  // R6: the stall only starts from a critical request that was taken
  assert_stall_from_critical_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reqValid && reqCritical));
  // R6: no request is taken while stalled
  assert_no_take_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !strobe.capture);
endmodule

// File: rtl/mpinj_datapath.sv
`timescale 1ns/1ps
module mpinj_datapath
  import mpinj_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int NUM_PATHS = 4,
  parameter int ID_W      = 8,
  parameter int HANDLE_W  = 16,
  parameter int WEIGHT_W  = 8,
  localparam int FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
  localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1,
  localparam int ADDR_W   = $clog2(NUM_PATHS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FLOW_W-1:0]   reqFlow,
  input  logic [HANDLE_W-1:0] reqHandle,
  input  logic                cfgWrite,
  input  logic [FLOW_W-1:0]   cfgFlow,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [WEIGHT_W-1:0] cfgData,
  input  ctrl_strobe_t        strobe,
  output logic [COPY_W-1:0]   reqCopies,
  output logic                outValid,
  output logic [FLOW_W-1:0]   outFlow,
  output logic [HANDLE_W-1:0] outHandle,
  output logic [PATH_W-1:0]   outPath,
  output logic [ID_W-1:0]     outSeqId,
  output logic [COPY_W-1:0]   outCopy
);
  localparam int WMAX = (1 << WEIGHT_W) - 1;

  logic [LFSR_W-1:0]   lfsrState;
  logic [WEIGHT_W-1:0] thresh [NUM_FLOWS][NUM_PATHS];
  logic [COPY_W-1:0]   copies [NUM_FLOWS];
  logic [ID_W-1:0]     idTable [NUM_FLOWS];
  logic [FLOW_W-1:0]   heldFlow;
  logic [HANDLE_W-1:0] heldHandle;
  logic [ID_W-1:0]     heldId;
  logic [FLOW_W-1:0]   selFlow;
  logic [NUM_PATHS*WEIGHT_W-1:0] curRow;
  logic [PATH_W-1:0]   drawnPath;

  mpinj_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsrState));

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      localparam int RAW = ((p + 1) * (1 << WEIGHT_W)) / NUM_PATHS;
      localparam int DEF = (RAW > WMAX) ? WMAX : RAW;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thresh[f][p] <= WEIGHT_W'(DEF);
        else if (cfgWrite && cfgFlow == FLOW_W'(f) && cfgAddr == ADDR_W'(p))
          thresh[f][p] <= cfgData;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) copies[f] <= COPY_W'(1);
      else if (cfgWrite && cfgFlow == FLOW_W'(f) && cfgAddr == ADDR_W'(NUM_PATHS))
        copies[f] <= cfgData[COPY_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idTable[f] <= ID_W'(1);
      else if (strobe.capture && reqFlow == FLOW_W'(f))
        idTable[f] <= idTable[f] + ID_W'(1);
    end
  end

  assign reqCopies = copies[reqFlow];
  assign selFlow   = strobe.capture ? reqFlow : heldFlow;

  always_comb begin
    for (int p = 0; p < NUM_PATHS; p++) curRow[p*WEIGHT_W +: WEIGHT_W] = thresh[selFlow][p];
  end

  mpinj_path_pick #(.NUM_PATHS(NUM_PATHS), .WEIGHT_W(WEIGHT_W)) u_pick (
    .randVal(lfsrState[WEIGHT_W-1:0]),
    .thrRow (curRow),
    .path   (drawnPath)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldFlow   <= '0;
      heldHandle <= '0;
      heldId     <= '0;
    end else if (strobe.capture) begin
      heldFlow   <= reqFlow;
      heldHandle <= reqHandle;
      heldId     <= idTable[reqFlow];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      outFlow   <= '0;
      outHandle <= '0;
      outPath   <= '0;
      outSeqId  <= '0;
      outCopy   <= '0;
    end else begin
      outValid <= strobe.emit;
      outCopy  <= strobe.copyNum;
      outPath  <= drawnPath;
      if (strobe.capture) begin
        outFlow   <= reqFlow;
        outHandle <= reqHandle;
        outSeqId  <= idTable[reqFlow];
      end else begin
        outFlow   <= heldFlow;
        outHandle <= heldHandle;
        outSeqId  <= heldId;
      end
    end
  end

  // R2: a taken request shows on the outputs after the same edge
  assert_emit_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> (outValid && outCopy == '0 &&
                        outFlow == $past(reqFlow) && outHandle == $past(reqHandle)));
  // R5: later copies repeat the sequence number and flow
  assert_copy_same_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outCopy != '0) |-> (outSeqId == $past(outSeqId) && outFlow == $past(outFlow)));
  // R3: taking a packet moves its flow's counter by exactly one
  assert_id_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> (idTable[$past(reqFlow)] == outSeqId + ID_W'(1)));
endmodule

// File: rtl/mpinj_top.sv
`timescale 1ns/1ps
module mpinj_top
  import mpinj_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int NUM_PATHS = 4,
  parameter int ID_W      = 8,
  parameter int HANDLE_W  = 16,
  parameter int WEIGHT_W  = 8,
  localparam int FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
  localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1,
  localparam int ADDR_W   = $clog2(NUM_PATHS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [FLOW_W-1:0]   reqFlow,
  input  logic                reqCritical,
  input  logic [HANDLE_W-1:0] reqHandle,
  output logic                reqReady,
  input  logic                cfgWrite,
  input  logic [FLOW_W-1:0]   cfgFlow,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [WEIGHT_W-1:0] cfgData,
  output logic                outValid,
  output logic [FLOW_W-1:0]   outFlow,
  output logic [HANDLE_W-1:0] outHandle,
  output logic [PATH_W-1:0]   outPath,
  output logic [ID_W-1:0]     outSeqId,
  output logic [COPY_W-1:0]   outCopy
);
  ctrl_strobe_t      strobe;
  logic [COPY_W-1:0] reqCopies;

  mpinj_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqCritical(reqCritical),
    .reqCopies(reqCopies), .reqReady(reqReady), .strobe(strobe)
  );

  mpinj_datapath #(
    .NUM_FLOWS(NUM_FLOWS), .NUM_PATHS(NUM_PATHS), .ID_W(ID_W),
    .HANDLE_W(HANDLE_W), .WEIGHT_W(WEIGHT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .reqFlow(reqFlow), .reqHandle(reqHandle),
    .cfgWrite(cfgWrite), .cfgFlow(cfgFlow), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strobe(strobe), .reqCopies(reqCopies), .outValid(outValid), .outFlow(outFlow),
    .outHandle(outHandle), .outPath(outPath), .outSeqId(outSeqId), .outCopy(outCopy)
  );

  // R1: nothing is emitted in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!outValid && reqReady));
endmodule

// File: tb/mpinj_top_test.sv
`timescale 1ns/1ps
module mpinj_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqFlow = '0;
  logic        reqCritical = 1'b0;
  logic [15:0] reqHandle = '0;
  logic        reqReady;
  logic        cfgWrite = 1'b0;
  logic [1:0]  cfgFlow = '0;
  logic [2:0]  cfgAddr = '0;
  logic [7:0]  cfgData = '0;
  logic        outValid;
  logic [1:0]  outFlow;
  logic [15:0] outHandle;
  logic [1:0]  outPath;
  logic [7:0]  outSeqId;
  logic [2:0]  outCopy;

  mpinj_top uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqFlow(reqFlow),
    .reqCritical(reqCritical), .reqHandle(reqHandle), .reqReady(reqReady),
    .cfgWrite(cfgWrite), .cfgFlow(cfgFlow), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .outValid(outValid), .outFlow(outFlow), .outHandle(outHandle), .outPath(outPath),
    .outSeqId(outSeqId), .outCopy(outCopy)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Bench model of the random register (R4, R8)
  logic [15:0] mLfsr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mLfsr <= 16'hACE1;
    else        mLfsr <= {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
  end

  int         mTh [4][4];
  int         mCop [4];
  logic [7:0] mId [4];
  int         hCnt = 0;

  // Vector table: flow, critical, expected emission count
  localparam int NV = 10;
  localparam int VFLOW [NV] = '{0, 1, 1, 2, 0, 3, 1, 2, 0, 2};
  localparam int VCRIT [NV] = '{0, 1, 0, 1, 1, 1, 1, 0, 0, 1};
  localparam int VCNT  [NV] = '{1, 3, 1, 2, 1, 1, 3, 1, 1, 2};

  task automatic modelReset();
    for (int f = 0; f < 4; f++) begin
      mTh[f][0] = 64; mTh[f][1] = 128; mTh[f][2] = 192; mTh[f][3] = 255;
      mCop[f] = 1;
      mId[f] = 8'd1;
    end
  endtask

  function automatic int pickPath(input int f, input logic [7:0] r);
    int p;
    p = 3;
    for (int i = 3; i >= 0; i--) if (int'(r) < mTh[f][i]) p = i;
    return p;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgWr(input int f, input int a, input int d);
    cfgWrite = 1'b1; cfgFlow = 2'(f); cfgAddr = 3'(a); cfgData = 8'(d);
    @(posedge clk); @(negedge clk);
    cfgWrite = 1'b0;
    if (a < 4) mTh[f][a] = d;
    else if (a == 4) mCop[f] = d & 7;
  endtask

  // Sends one request at a negedge and checks every emission it causes
  task automatic doReq(input int f, input bit crit, input int expCount, input string tag);
    logic [15:0] h;
    logic [7:0]  eid;
    int          pred;
    h = 16'h5000 + 16'(hCnt); hCnt++;
    eid = mId[f]; mId[f] = mId[f] + 8'd1;
    chk({tag, " R6 ready before request"}, int'(reqReady), 1);
    reqValid = 1'b1; reqFlow = 2'(f); reqCritical = crit; reqHandle = h;
    pred = pickPath(f, mLfsr[7:0]);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < expCount; k++) begin
      chk({tag, " R2 outValid"}, int'(outValid), 1);
      chk({tag, " R3 seq id"}, int'(outSeqId), int'(eid));
      chk({tag, " R4 path"}, int'(outPath), pred);
      chk({tag, " R5 copy index"}, int'(outCopy), k);
      chk({tag, " R2 flow"}, int'(outFlow), f);
      chk({tag, " R2 handle"}, int'(outHandle), int'(h));
      chk({tag, " R6 ready during copies"}, int'(reqReady), (k == expCount - 1) ? 1 : 0);
      pred = pickPath(f, mLfsr[7:0]);
      @(posedge clk); @(negedge clk);
    end
    chk({tag, " R5 no extra copy"}, int'(outValid), 0);
  endtask

  function automatic int cntFor(input int f, input bit crit);
    if (!crit) return 1;
    return (mCop[f] < 2) ? 1 : mCop[f];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    modelReset();
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 outValid in reset", int'(outValid), 0);
    chk("R1 reqReady in reset", int'(reqReady), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", int'(outValid), 0);
    chk("R1 reqReady after reset", int'(reqReady), 1);

    // R7: configuration
    cfgWr(1, 4, 3);
    cfgWr(2, 4, 2);
    cfgWr(3, 4, 0);
    for (int p = 0; p < 4; p++) cfgWr(1, p, 0);
    for (int p = 0; p < 4; p++) cfgWr(2, p, 255);
    cfgWr(3, 0, 10); cfgWr(3, 1, 20); cfgWr(3, 2, 30); cfgWr(3, 3, 40);
    // R7: unused addresses change nothing
    cfgWr(0, 5, 7); mTh[0][0] = 64;
    cfgWr(0, 6, 0); cfgWr(0, 7, 0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      chk("R5 table count vs config", cntFor(VFLOW[i], VCRIT[i] != 0), VCNT[i]);
      doReq(VFLOW[i], VCRIT[i] != 0, VCNT[i], $sformatf("vec%0d", i));
    end

    // R7: unused-address writes left flow0 copy count at 1
    doReq(0, 1'b1, 1, "R7 unused addr");

    // R6: request presented while stalled is ignored
    begin
      logic [7:0] eid;
      int pred;
      eid = mId[1]; mId[1] = mId[1] + 8'd1;
      reqValid = 1'b1; reqFlow = 2'd1; reqCritical = 1'b1; reqHandle = 16'hBEEF;
      pred = pickPath(1, mLfsr[7:0]);
      @(posedge clk); @(negedge clk);
      reqFlow = 2'd2; reqCritical = 1'b0; reqHandle = 16'h1234;
      for (int k = 0; k < 3; k++) begin
        chk("R6 stalled copy valid", int'(outValid), 1);
        chk("R6 stalled copy flow", int'(outFlow), 1);
        chk("R6 stalled copy id", int'(outSeqId), int'(eid));
        chk("R6 stalled copy path", int'(outPath), pred);
        chk("R6 stalled copy index", int'(outCopy), k);
        pred = pickPath(1, mLfsr[7:0]);
        if (k == 2) reqValid = 1'b0;
        @(posedge clk); @(negedge clk);
      end
      chk("R6 ignored request made no emission", int'(outValid), 0);
      doReq(2, 1'b0, 1, "R6 counter not advanced");
    end

    // R8: idle gap, then draws still follow the running register
    repeat (37) @(negedge clk);
    doReq(0, 1'b0, 1, "R8 after idle");
    repeat (5) @(negedge clk);
    doReq(3, 1'b0, 1, "R8 after idle flow3");

    // R7: threshold rewrite applies to the next draw
    cfgWr(0, 0, 0); cfgWr(0, 1, 0); cfgWr(0, 2, 128);
    for (int i = 0; i < 6; i++) doReq(0, 1'b0, 1, "R7 rewritten thresholds");
    cfgWr(2, 4, 5);
    doReq(2, 1'b1, 5, "R7 new copy count");

    // R3: wrap of flow 3 counter past 255
    for (int i = 0; i < 260; i++) doReq(3, 1'b0, 1, "R3 wrap");
    chk("R3 counter wrapped", int'(mId[3] < 8'd10), 1);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    modelReset();
    @(negedge clk);
    chk("R1 outValid mid reset", int'(outValid), 0);
    chk("R1 reqReady mid reset", int'(reqReady), 1);
    rst_n = 1'b1;
    @(negedge clk);
    doReq(1, 1'b1, 1, "R1 defaults restored");
    doReq(3, 1'b0, 1, "R1 id restart");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule